// File: doc/BRIEF.md
# Variable Pulse Width Receive Symbol Classifier

This block watches the receive line of a single-wire variable pulse width bus. Each active or passive stretch of the line is measured in clock periods, and the block names the stretch: a data bit, start of frame, end of data, end of frame, inter-frame separation, break, idle, or an invalid pulse. The clock period is the measurement resolution. Every window edge is a parameter counted in clock ticks.

The raw input first goes through a two-flop synchroniser. It then passes a three-sample majority vote, which removes single-sample spikes before any transition is seen. The decision windows touch each other with no gap between them. A width exactly on a boundary goes to the longer category. The same width means different things on an active stretch and on a passive stretch.

Passive stretches are reported while they are still growing. End of data, end of frame, separation and idle each fire once, in the cycle the running count reaches their threshold, and no new transition is needed. Active stretches are reported when they end. The result leaves the block as a one-cycle strobe with a symbol code and a bit value. Assembling bytes, checking the CRC, arbitration and transmit are left to the blocks around it.

Top module: `vpw_rx_classifier`

## Requirements
- R1: A high pulse on `bus_i` that lasts one clock sample is suppressed by the majority vote. The passive stretch around it is measured as one unbroken period.
- R2: An active stretch of width w with T_SHORT <= w < T_LONG reports data with bit 1. T_LONG <= w < T_FRAME reports data with bit 0. A width equal to T_LONG is a 0.
- R3: A passive stretch ending with T_SHORT <= w < T_LONG reports data with bit 0. T_LONG <= w < T_FRAME reports data with bit 1. A width equal to T_LONG is a 1.
- R4: An active stretch with T_FRAME <= w < T_END reports start of frame when it ends. One with w >= T_END reports break. A width equal to T_END is a break.
- R5: A passive stretch reports end of data when its count reaches T_FRAME. It reports end of frame at T_END, separation at T_IFS, and idle at T_IFS+1. Each fires once, in the order reached. The transition that ends such a stretch reports nothing more.
- R6: An active or passive stretch shorter than T_SHORT reports invalid when it ends.
- R7: The strobe is low during reset. After reset the width counter starts saturated, so no symbol is reported until the first transition. The counter holds at its maximum and never wraps.
- R8: `sym_code_o` encoding: 0 data, 1 start of frame, 2 end of data, 3 end of frame, 4 separation, 5 break, 6 idle, 7 invalid. `sym_bit_o` carries the bit for code 0 and is 0 for every other code. `bus_i` high is the active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one period is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 1 | Raw bus receive level, 1 = active |
| sym_valid_o | output | 1 | One-cycle strobe: a symbol was classified |
| sym_code_o | output | 3 | Symbol code, see R8 |
| sym_bit_o | output | 1 | Data bit value when the code is data |

## Verification
The bench builds the block with windows of 4, 8, 12, 16 and 20 ticks in place of the microsecond-scale defaults. At that scale every window and every boundary, on both the active and the passive side, is reached in a few tens of cycles. So each boundary width is driven, together with the width one below it, and passive stretches run past the end-of-frame, separation and idle thresholds in a single short run. A one-sample spike placed inside a passive stretch tests the majority vote against the width the scoreboard expects.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;
  typedef enum logic [2:0] {
    SYM_DATA    = 3'd0,
    SYM_SOF     = 3'd1,
    SYM_EOD     = 3'd2,
    SYM_EOF     = 3'd3,
    SYM_IFS     = 3'd4,
    SYM_BREAK   = 3'd5,
    SYM_IDLE    = 3'd6,
    SYM_INVALID = 3'd7
  } vpw_sym_e;
endpackage

// File: rtl/vpw_rx_filter.sv
module vpw_rx_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_i,
  output logic level_o
);
  localparam int VOTE_NEED = VOTE_TAPS / 2 + 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [VOTE_TAPS-1:0]   tap_q, tap_d;
  logic                   vote_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], bus_i};
    tap_d  = {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
    vote_d = ($countones(tap_q) >= VOTE_NEED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      tap_q   <= '0;
      level_o <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      tap_q   <= tap_d;
      level_o <= vote_d;
    end
  end

  // R1: a unanimous tap window forces the filtered level
  a_r1_vote_high: assert property (@(posedge clk) disable iff (!rst_n)
    (&tap_q) |=> level_o);
  a_r1_vote_low: assert property (@(posedge clk) disable iff (!rst_n)
    (~|tap_q) |=> !level_o);
endmodule

// File: rtl/vpw_rx_timer.sv
module vpw_rx_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  output logic             level_q,
  output logic [CNT_W-1:0] width_q,
  output logic             edge_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] width_d;

  always_comb begin
    edge_o = (level_i != level_q);
    if (edge_o)                 width_d = CNT_W'(1);
    else if (width_q == CNT_MAX) width_d = width_q;
    else                        width_d = width_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      width_q <= CNT_MAX;
    end else begin
      level_q <= level_i;
      width_q <= width_d;
    end
  end

  // R7: saturation holds, count never returns to zero
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q == CNT_MAX && !edge_o) |=> (width_q == CNT_MAX));
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    width_q != '0);
endmodule

// File: rtl/vpw_rx_decode.sv
module vpw_rx_decode
  import vpw_rx_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int T_SHORT = 34,
  parameter int T_LONG  = 96,
  parameter int T_FRAME = 163,
  parameter int T_END   = 239,
  parameter int T_IFS   = 280
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             edge_i,
  output logic             valid_o,
  output vpw_sym_e         code_o,
  output logic             bit_o
);
  localparam logic [CNT_W-1:0] W_SHORT = CNT_W'(T_SHORT);
  localparam logic [CNT_W-1:0] W_LONG  = CNT_W'(T_LONG);
  localparam logic [CNT_W-1:0] W_FRAME = CNT_W'(T_FRAME);
  localparam logic [CNT_W-1:0] W_END   = CNT_W'(T_END);
  localparam logic [CNT_W-1:0] W_IFS   = CNT_W'(T_IFS);
  localparam logic [CNT_W-1:0] W_IDLE  = CNT_W'(T_IFS + 1);

  logic     hit_d, bit_d;
  vpw_sym_e code_d;

  always_comb begin
    hit_d  = 1'b0;
    code_d = SYM_DATA;
    bit_d  = 1'b0;
    if (!level_i) begin
      // passive: long symbols fire as the count reaches them
      if (width_i == W_FRAME) begin
        hit_d = 1'b1; code_d = SYM_EOD;
      end else if (width_i == W_END) begin
        hit_d = 1'b1; code_d = SYM_EOF;
      end else if (width_i == W_IFS) begin
        hit_d = 1'b1; code_d = SYM_IFS;
      end else if (width_i == W_IDLE) begin
        hit_d = 1'b1; code_d = SYM_IDLE;
      end else if (edge_i && width_i < W_FRAME) begin
        hit_d = 1'b1;
        if (width_i < W_SHORT)     code_d = SYM_INVALID;
        else if (width_i < W_LONG) bit_d  = 1'b0;
        else                       bit_d  = 1'b1;
      end
    end else if (edge_i) begin
      hit_d = 1'b1;
      if (width_i < W_SHORT)      code_d = SYM_INVALID;
      else if (width_i < W_LONG)  bit_d  = 1'b1;
      else if (width_i < W_FRAME) bit_d  = 1'b0;
      else if (width_i < W_END)   code_d = SYM_SOF;
      else                        code_d = SYM_BREAK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      code_o  <= SYM_DATA;
      bit_o   <= 1'b0;
    end else begin
      valid_o <= hit_d;
      code_o  <= code_d;
      bit_o   <= bit_d;
    end
  end

  // R2: every end of an active stretch produces a strobe
  a_r2_active_end_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && level_i) |=> valid_o);
  // R5: end of data is reported once per stretch
  a_r5_eod_once: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && code_o == SYM_EOD) |=> !(valid_o && code_o == SYM_EOD));
  // R6: invalid only follows a width below the short window
  a_r6_invalid_short: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && code_o == SYM_INVALID) |-> ($past(width_i) < W_SHORT));
  // R8: bit value is zero outside data symbols
  a_r8_bit_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && code_o != SYM_DATA) |-> !bit_o);
endmodule

// File: rtl/vpw_rx_classifier.sv
module vpw_rx_classifier
  import vpw_rx_pkg::*;
#(
  parameter int T_SHORT = 34,
  parameter int T_LONG  = 96,
  parameter int T_FRAME = 163,
  parameter int T_END   = 239,
  parameter int T_IFS   = 280
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_i,
  output logic       sym_valid_o,
  output logic [2:0] sym_code_o,
  output logic       sym_bit_o
);
  localparam int CNT_W = $clog2(T_IFS + 2) + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             level_f, level_q, edge_w;
  logic [CNT_W-1:0] width_w;
  vpw_sym_e         code_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  vpw_rx_filter #(.SYNC_STAGES(2), .VOTE_TAPS(3)) u_filter (
    .clk(clk), .rst_n(rst_n_s), .bus_i(bus_i), .level_o(level_f)
  );

  vpw_rx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .level_i(level_f),
    .level_q(level_q), .width_q(width_w), .edge_o(edge_w)
  );

  vpw_rx_decode #(
    .CNT_W(CNT_W), .T_SHORT(T_SHORT), .T_LONG(T_LONG),
    .T_FRAME(T_FRAME), .T_END(T_END), .T_IFS(T_IFS)
  ) u_decode (
    .clk(clk), .rst_n(rst_n_s), .level_i(level_q), .width_i(width_w),
    .edge_i(edge_w), .valid_o(sym_valid_o), .code_o(code_w), .bit_o(sym_bit_o)
  );

  assign sym_code_o = code_w;
endmodule

// File: tb/tb_vpw_rx_classifier.sv
module tb_vpw_rx_classifier;
  import vpw_rx_pkg::*;

  localparam int S = 4, L = 8, F = 12, E = 16, I = 20;

  logic       clk, rst_n, bus;
  logic       sym_valid_o, sym_bit_o;
  logic [2:0] sym_code_o;

  int    n_vec, n_bad;
  bit    done;
  logic [3:0] expq[$];
  string tagq[$];

  vpw_rx_classifier #(.T_SHORT(S), .T_LONG(L), .T_FRAME(F), .T_END(E), .T_IFS(I)) dut (
    .clk(clk), .rst_n(rst_n), .bus_i(bus),
    .sym_valid_o(sym_valid_o), .sym_code_o(sym_code_o), .sym_bit_o(sym_bit_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic expect_sym(input vpw_sym_e c, input logic b, input string tag);
    expq.push_back({3'(c), b});
    tagq.push_back(tag);
  endtask

  task automatic hold(input logic lvl, input int n);
    bus = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic active(input int n, input vpw_sym_e c, input logic b, input string tag);
    expect_sym(c, b, tag);
    hold(1'b1, n);
  endtask

  task automatic passive_bit(input int n, input vpw_sym_e c, input logic b, input string tag);
    expect_sym(c, b, tag);
    hold(1'b0, n);
  endtask

  task automatic passive_long(input int n);
    if (n >= F) expect_sym(SYM_EOD,  1'b0, "R5 eod");
    if (n >= E) expect_sym(SYM_EOF,  1'b0, "R5 eof");
    if (n >= I) expect_sym(SYM_IFS,  1'b0, "R5 ifs");
    if (n >  I) expect_sym(SYM_IDLE, 1'b0, "R5 idle");
    hold(1'b0, n);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && sym_valid_o) begin
      n_vec++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R7 unexpected strobe: got code %0d bit %0d, expected none",
                 sym_code_o, sym_bit_o);
      end else begin
        logic [3:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({sym_code_o, sym_bit_o} !== e) begin
          n_bad++;
          $display("FAIL %s: got code %0d bit %0d, expected code %0d bit %0d",
                   t, sym_code_o, sym_bit_o, e[3:1], e[0]);
        end
      end
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    bus = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    n_vec++;
    if (sym_valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 reset strobe: got %0d, expected 0", sym_valid_o);
    end
    rst_n = 1'b1;
    hold(1'b0, 60);   // R7: no reports before first transition
    active(6,  SYM_DATA, 1'b1, "R2 active short");
    passive_bit(5, SYM_DATA, 1'b0, "R3 passive short");
    active(10, SYM_DATA, 1'b0, "R2 active long");
    passive_bit(9, SYM_DATA, 1'b1, "R3 passive long");
    active(S,  SYM_DATA, 1'b1, "R2 at short min");
    passive_bit(S, SYM_DATA, 1'b0, "R3 at short min");
    active(S-1, SYM_INVALID, 1'b0, "R6 active too short");
    passive_bit(L, SYM_DATA, 1'b1, "R3 at long boundary");
    active(L,  SYM_DATA, 1'b0, "R2 at long boundary");
    passive_bit(L-1, SYM_DATA, 1'b0, "R3 below long boundary");
    active(L-1, SYM_DATA, 1'b1, "R2 below long boundary");
    passive_bit(S-1, SYM_INVALID, 1'b0, "R6 passive too short");
    active(F,  SYM_SOF, 1'b0, "R4 sof at boundary");
    passive_long(F);
    active(F-1, SYM_DATA, 1'b0, "R2 below sof");
    passive_long(14);
    active(E,  SYM_BREAK, 1'b0, "R4 break at boundary");
    passive_long(E);
    active(E-1, SYM_SOF, 1'b0, "R4 below break");
    passive_long(I);
    active(5,  SYM_DATA, 1'b1, "R2 after ifs");
    passive_long(I+1);
    active(9,  SYM_DATA, 1'b0, "R2 after idle");
    passive_long(40);
    active(5,  SYM_DATA, 1'b1, "R2 before spike");
    // R1: one-sample spike inside a passive stretch of 3+1+3 = 7
    expect_sym(SYM_DATA, 1'b0, "R1 spike filtered");
    hold(1'b0, 3); hold(1'b1, 1); hold(1'b0, 3);
    active(6,  SYM_DATA, 1'b1, "R1 after spike");
    passive_long(30);
    repeat (10) @(negedge clk);
    n_vec++;
    if (expq.size() != 0) begin
      n_bad++;
      $display("FAIL R5 missing strobes: got %0d left, expected 0", expq.size());
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule